// File: doc/BRIEF.md
# Linear-to-page flash address translator

This block turns a linear byte address into the address form expected by a serial flash whose pages are 264 or 528 bytes long. In that form the page number does not follow the byte offset directly. The offset sits in a fixed low field: 9 bits wide for 264-byte pages and 10 bits wide for 528-byte pages. The page number sits above that field. The block finds the page number and the offset with an iterative restoring divider and then packs the two into a 24-bit device address. That address is three bytes long, ready for a command sequencer to send.

A request is a single `start` pulse that comes with a page-size select, an addressing-mode flag and a 22-bit linear address. When the flash runs in its power-of-two page mode, the address goes through without change. Any address at or beyond the device capacity is rejected. Both of these cases finish one cycle after the request. A division takes 23 cycles. When the result is ready, `done` pulses for one cycle, and the result then stays on the outputs until the next request that is accepted.

Top module: `flash_addr_xlate`

## Requirements
- R1: While `rst_n` is low at a clock edge, `done`, `busy`, `out_of_range` and `dev_addr` are all cleared to zero.
- R2: With `page_528`=0 and `pow2_mode`=0, an accepted in-range address A yields `dev_addr` = ((A / 264) << 9) | (A mod 264). `done` is high in the 24th cycle after the cycle in which `start` was accepted.
- R3: With `page_528`=1 and `pow2_mode`=0, an accepted in-range address A yields `dev_addr` = ((A / 528) << 10) | (A mod 528), with the same latency as R2.
- R4: With `pow2_mode`=1, an accepted in-range address is copied to `dev_addr` with zero extension. `done` is high in the cycle after the request, and `busy` stays low.
- R5: Capacity is 4096 pages times the page size. The page size is 264 or 528 bytes when `pow2_mode`=0 and 256 or 512 bytes when it is 1, picked by `page_528`. An address at or above the capacity sets `out_of_range`=1, forces `dev_addr` to zero and raises `done` in the next cycle. Any other accepted request clears `out_of_range`.
- R6: While `busy` is high, `start` is ignored and so are changes on `lin_addr`, `page_528` and `pow2_mode`. The running conversion finishes with the operands that were captured when it was accepted.
- R7: `done` is high for one cycle per accepted request. `dev_addr` and `out_of_range` keep their values until the next accepted request changes them.
- R8: `busy` is high from the cycle after a division is accepted until the result is delivered. `busy` and `done` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request strobe, accepted when `busy` is low |
| page_528 | input | 1 | Page size select: 1 = 528/512 bytes, 0 = 264/256 bytes |
| pow2_mode | input | 1 | 1 = power-of-two page mode, address passes through |
| lin_addr | input | 22 | Linear byte address |
| dev_addr | output | 24 | Translated device address |
| done | output | 1 | One-cycle result strobe |
| busy | output | 1 | Division in progress |
| out_of_range | output | 1 | Last accepted address exceeded capacity |

## Verification
The assertions assume that `lin_addr` and the mode inputs are valid in any cycle where `start` is high. They also assume that the reset is held for at least one clock edge before any request. The bench drives every input on the falling edge and holds each one stable across the rising edge that samples it, so these assumptions always hold. Requests during `busy` are made deliberately, with changed operands, to show that they are dropped.

// File: rtl/xl_pkg.sv
// Package xl_pkg: shared helpers for the address translator.
// Assumes page sizes below 1024 bytes so that a 10-bit field holds them.
package xl_pkg;
    // Bytes per page for the given mode and size select.
    function automatic logic [9:0] page_bytes(input logic pow2, input logic big);
        if (pow2)
            return big ? 10'd512 : 10'd256;
        else
            return big ? 10'd528 : 10'd264;
    endfunction

    // Width of the offset field in the packed device address.
    function automatic logic [3:0] off_bits(input logic big);
        return big ? 4'd10 : 4'd9;
    endfunction
endpackage

// File: rtl/xl_range_chk.sv
// Module xl_range_chk: flags an address at or beyond device capacity.
// Assumes PAGE_CNT * 528 fits in ADDR_W+2 bits. Purely combinational.
module xl_range_chk
    import xl_pkg::*;
#(
    parameter int ADDR_W   = 22,
    parameter int PAGE_CNT = 4096
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              pow2,
    input  logic              big,
    output logic              over
);
    localparam int CAP_W = ADDR_W + 2;

    logic [CAP_W-1:0] cap;

    // Capacity for the selected mode, then compare.
    always_comb begin
        cap  = CAP_W'(PAGE_CNT) * CAP_W'(page_bytes(pow2, big));
        over = ({2'b00, addr} >= cap);
    end
endmodule

// File: rtl/xl_divider.sv
// Module xl_divider: restoring shift-subtract divider, one quotient bit per
// clock. A load pulse captures the operands. N steps follow, and valid pulses
// once afterwards with quotient and remainder held until the next load.
// Assumes divisor is non-zero and load is not pulsed while a run is active.
module xl_divider #(
    parameter int N   = 22,
    parameter int D_W = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [N-1:0]   dividend,
    input  logic [D_W-1:0] divisor,
    output logic [N-1:0]   quotient,
    output logic [D_W-1:0] remainder,
    output logic           valid
);
    localparam int CNT_W = $clog2(N);

    logic [D_W-1:0]   div_q;
    logic [CNT_W-1:0] cnt;
    logic             run;
    logic [D_W:0]     trial;
    logic             fits;
    logic [D_W-1:0]   rem_n;
    logic [N-1:0]     quo_n;

    // One restoring step: shift in the next dividend bit, subtract if it fits.
    always_comb begin
        trial = {remainder, quotient[N-1]};
        fits  = (trial >= {1'b0, div_q});
        rem_n = fits ? D_W'(trial - {1'b0, div_q}) : trial[D_W-1:0];
        quo_n = {quotient[N-2:0], fits};
    end

    // Operand capture, iteration count and completion strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q     <= '0;
            cnt       <= '0;
            run       <= 1'b0;
            quotient  <= '0;
            remainder <= '0;
            valid     <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (load) begin
                div_q     <= divisor;
                quotient  <= dividend;
                remainder <= '0;
                cnt       <= '0;
                run       <= 1'b1;
            end else if (run) begin
                quotient  <= quo_n;
                remainder <= rem_n;
                cnt       <= cnt + 1'b1;
                if (cnt == CNT_W'(N - 1)) begin
                    run   <= 1'b0;
                    valid <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/flash_addr_xlate.sv
// Module flash_addr_xlate: converts a linear byte address into the packed
// page/offset address of a flash with 264- or 528-byte pages. In power-of-two
// mode the address passes through. Addresses beyond capacity give zero and a
// flag. Assumes operands are valid whenever start is high.
module flash_addr_xlate
    import xl_pkg::*;
#(
    parameter int ADDR_W   = 22,
    parameter int OUT_W    = 24,
    parameter int REM_W    = 10,
    parameter int PAGE_CNT = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              page_528,
    input  logic              pow2_mode,
    input  logic [ADDR_W-1:0] lin_addr,
    output logic [OUT_W-1:0]  dev_addr,
    output logic              done,
    output logic              busy,
    output logic              out_of_range
);
    logic              accept;
    logic              over;
    logic              div_load;
    logic              div_valid;
    logic [ADDR_W-1:0] quo;
    logic [REM_W-1:0]  rem;
    logic              big_q;
    logic [OUT_W-1:0]  joined;

    xl_range_chk #(
        .ADDR_W   (ADDR_W),
        .PAGE_CNT (PAGE_CNT)
    ) u_range (
        .addr (lin_addr),
        .pow2 (pow2_mode),
        .big  (page_528),
        .over (over)
    );

    xl_divider #(
        .N   (ADDR_W),
        .D_W (REM_W)
    ) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (div_load),
        .dividend  (lin_addr),
        .divisor   (page_bytes(1'b0, page_528)),
        .quotient  (quo),
        .remainder (rem),
        .valid     (div_valid)
    );

    // Request acceptance and the choice of path for it.
    always_comb begin
        accept   = start && !busy;
        div_load = accept && !over && !pow2_mode;
    end

    // Pack the page number above the offset field.
    always_comb begin
        joined = (OUT_W'(quo) << off_bits(big_q)) | OUT_W'(rem);
    end

    // Result registers, busy tracking and the done strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dev_addr     <= '0;
            done         <= 1'b0;
            busy         <= 1'b0;
            out_of_range <= 1'b0;
            big_q        <= 1'b0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                big_q <= page_528;
                if (over) begin
                    dev_addr     <= '0;
                    out_of_range <= 1'b1;
                    done         <= 1'b1;
                end else if (pow2_mode) begin
                    dev_addr     <= OUT_W'(lin_addr);
                    out_of_range <= 1'b0;
                    done         <= 1'b1;
                end else begin
                    out_of_range <= 1'b0;
                    busy         <= 1'b1;
                end
            end else if (busy && div_valid) begin
                dev_addr <= joined;
                busy     <= 1'b0;
                done     <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/xl_checker.sv
// Module xl_checker: temporal properties of flash_addr_xlate, bound to it.
// Assumes inputs are stable around the sampling edge.
module xl_checker
    import xl_pkg::*;
#(
    parameter int ADDR_W   = 22,
    parameter int OUT_W    = 24,
    parameter int PAGE_CNT = 4096
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              page_528,
    input logic              pow2_mode,
    input logic [ADDR_W-1:0] lin_addr,
    input logic [OUT_W-1:0]  dev_addr,
    input logic              done,
    input logic              busy,
    input logic              out_of_range
);
    logic [ADDR_W+1:0] cap_c;

    // Capacity seen by the checker for the current inputs.
    always_comb cap_c = (ADDR_W+2)'(PAGE_CNT) * (ADDR_W+2)'(page_bytes(pow2_mode, page_528));

    assert_passthru_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && pow2_mode && ({2'b00, lin_addr} < cap_c))
        |=> (done && dev_addr == {{(OUT_W-ADDR_W){1'b0}}, $past(lin_addr)}));

    assert_oor_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && out_of_range) |-> (dev_addr == '0));

    assert_busy_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (done || $stable(dev_addr)));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !done);

    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(dev_addr) && $stable(out_of_range)));

    assert_busy_done_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    assert_busy_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done));
endmodule

bind flash_addr_xlate xl_checker #(
    .ADDR_W   (ADDR_W),
    .OUT_W    (OUT_W),
    .PAGE_CNT (PAGE_CNT)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .page_528     (page_528),
    .pow2_mode    (pow2_mode),
    .lin_addr     (lin_addr),
    .dev_addr     (dev_addr),
    .done         (done),
    .busy         (busy),
    .out_of_range (out_of_range)
);

// File: tb/flash_addr_xlate_tb.sv
module flash_addr_xlate_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        page_528 = 1'b0;
    logic        pow2_mode = 1'b0;
    logic [21:0] lin_addr = '0;
    logic [23:0] dev_addr;
    logic        done;
    logic        busy;
    logic        out_of_range;

    int    total = 0;
    int    bad = 0;
    bit    finished = 0;
    string cur_req = "R1";

    // Behavioural reference state.
    int m_left = 0;
    int m_pend = 0;
    int m_addr = 0;
    bit m_done = 0;
    bit m_oor = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_addr_xlate u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .page_528(page_528),
        .pow2_mode(pow2_mode), .lin_addr(lin_addr), .dev_addr(dev_addr),
        .done(done), .busy(busy), .out_of_range(out_of_range)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int psize(input bit p2, input bit big);
        if (p2) return big ? 512 : 256;
        return big ? 528 : 264;
    endfunction

    // Reference model, advanced on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_left <= 0; m_done <= 0; m_addr <= 0; m_oor <= 0;
        end else begin
            m_done <= 0;
            if (m_left == 0 && start) begin
                int ps;
                int a;
                ps = psize(pow2_mode, page_528);
                a  = int'(lin_addr);
                if (a >= 4096 * ps) begin
                    m_addr <= 0; m_oor <= 1; m_done <= 1;
                end else if (pow2_mode) begin
                    m_addr <= a; m_oor <= 0; m_done <= 1;
                end else begin
                    m_oor  <= 0;
                    m_left <= 23;
                    m_pend <= ((a / ps) << (page_528 ? 10 : 9)) | (a % ps);
                end
            end else if (m_left > 0) begin
                if (m_left == 1) begin
                    m_done <= 1;
                    m_addr <= m_pend;
                end
                m_left <= m_left - 1;
            end
        end
    end

    // Compare DUT against the model on every falling edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(m_left > 0 ? "R8" : "R7", "busy", int'(busy), int'(m_left > 0));
            chk(cur_req, "done", int'(done), int'(m_done));
            chk(cur_req, "dev_addr", int'(dev_addr), m_addr);
            chk("R5", "out_of_range", int'(out_of_range), int'(m_oor));
        end
    end

    task automatic issue(input string req, input int a, input bit big, input bit p2);
        @(negedge clk);
        cur_req   = req;
        lin_addr  = 22'(a);
        page_528  = big;
        pow2_mode = p2;
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (m_left > 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs cleared while reset is held.
        chk("R1", "done", int'(done), 0);
        chk("R1", "busy", int'(busy), 0);
        chk("R1", "oor", int'(out_of_range), 0);
        chk("R1", "dev_addr", int'(dev_addr), 0);
        rst_n = 1'b1;

        // R2: 264-byte pages.
        issue("R2", 0, 0, 0);
        issue("R2", 263, 0, 0);
        issue("R2", 264, 0, 0);
        issue("R2", 100_000, 0, 0);
        issue("R2", 1_081_343, 0, 0);
        chk("R2", "last page", int'(dev_addr), (4095 << 9) | 263);
        // R3: 528-byte pages.
        issue("R3", 527, 1, 0);
        issue("R3", 528, 1, 0);
        issue("R3", 12_345, 1, 0);
        issue("R3", 2_162_687, 1, 0);
        chk("R3", "last page", int'(dev_addr), (4095 << 10) | 527);
        // R4: power-of-two pass-through.
        issue("R4", 'h12345, 0, 1);
        issue("R4", 'h1FFFFF, 1, 1);
        // R5: out of range in each mode.
        issue("R5", 1_081_344, 0, 0);
        issue("R5", 2_162_688, 1, 0);
        issue("R5", 1_048_576, 0, 1);
        issue("R5", 'h3FFFFF, 1, 1);
        chk("R5", "oor flag", int'(out_of_range), 1);
        // R6: requests with changed operands while busy are dropped.
        @(negedge clk);
        cur_req = "R6";
        lin_addr = 22'd50_000; page_528 = 0; pow2_mode = 0; start = 1;
        @(negedge clk);
        start = 0;
        repeat (5) @(negedge clk);
        lin_addr = 22'h3FFFFF; page_528 = 1; pow2_mode = 1; start = 1;
        repeat (3) @(negedge clk);
        start = 0;
        while (m_left > 0) @(negedge clk);
        chk("R6", "captured result", int'(dev_addr), ((50_000 / 264) << 9) | (50_000 % 264));
        repeat (2) @(negedge clk);
        // R7: back-to-back one-cycle requests, then an idle hold.
        @(negedge clk);
        cur_req = "R7";
        lin_addr = 22'd777; page_528 = 0; pow2_mode = 1; start = 1;
        @(negedge clk);
        lin_addr = 22'd888;
        @(negedge clk);
        start = 0;
        repeat (6) @(negedge clk);
        chk("R7", "held address", int'(dev_addr), 888);
        finish_run();
    end
endmodule